// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is a bank of general-purpose I/O lines (32 by default) controlled through a small word-addressed register window. Each line has three settings: an output value, a direction bit, and an input inversion bit. A fourth word only stores a per-line blink-enable setting. The pins pass through a two-stage synchroniser and are then optionally inverted. The result is readable by software and feeds the interrupt logic.

The interrupt logic handles two kinds of event on each line. Edge events are latched into a sticky cause word. Level events are taken straight from the corrected input. Each kind has its own mask. The masked requests of each run of eight consecutive lines are ORed into one summary interrupt output. Software chooses falling-edge or active-low detection by setting the inversion bit of the line. It acknowledges edge events by writing zeros to the cause word.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is asserted and right after it, every register reads zero. `pin_out` is all zeros, `pin_oe` is all ones, and `irq_grp` is zero.
- R2: `pin_out` always equals the output-value word at byte offset 0x00. `pin_oe[i]` is 1 when bit i of the direction word at offset 0x04 is 0, and 0 when that bit is 1 (1 = input). A write takes effect on the pins in the cycle after the write edge.
- R3: The words at offsets 0x00, 0x04, 0x08 (blink enable, storage only), 0x0C (inversion), 0x18 (edge mask) and 0x1C (level mask) read back the last value written to them. Reads are combinational from the current state.
- R4: Offset 0x10 reads the synchronised pin value XOR the inversion word. A pin change becomes visible after two clock edges.
- R5: A cause bit is set on the edge after the corrected input of its line was observed going from 0 to 1 between two consecutive cycles. With inversion bit 0 this catches a rising pin; with inversion bit 1 it catches a falling pin. A 1-to-0 transition of the corrected input sets nothing.
- R6: Writing to the cause word at offset 0x14 clears each bit written as 0 and leaves each bit written as 1 unchanged. A cause bit only drops on such a write. An edge set in the same cycle as a clear wins, so the bit stays set.
- R7: `irq_grp[g]` is the OR over lines 8g to 8g+7 of (corrected input AND level mask) OR (cause AND edge mask). With both masks zero, `irq_grp` is zero.
- R8: Offsets 0x20 to 0x3C read zero, and writes to them change nothing. Writes to offset 0x10 change nothing.
- R9: With the inversion bit and the level-mask bit of a line set, its group output is raised while the pin is low and dropped when the pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Byte offset of the register access; bits [1:0] are ignored |
| reg_wen | input | 1 | Write strobe for the word at `reg_addr` |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the word at `reg_addr` (combinational) |
| pin_in | input | 32 | Raw pin levels (asynchronous) |
| pin_out | output | 32 | Output value per line |
| pin_oe | output | 32 | Output enable per line, 1 = drive |
| irq_grp | output | 4 | Summary interrupt per group of eight lines |

## Verification
The bench builds the port with its default parameters: 32 lines, groups of eight, two synchroniser stages and a 6-bit offset. All four summary outputs and the whole unmapped half of the offset window can therefore be exercised. A behavioural model follows the two-edge input latency and the set-over-clear rule bit by bit. Directed sequences place a pin edge in exactly the cycle of a clearing write and drive both inverted edge and level detection. A long random phase then mixes writes to every offset with pin toggles.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   // Word index inside the register window (byte offset >> 2)
   typedef enum logic [2:0] {
      RG_OUT   = 3'd0,
      RG_DIR   = 3'd1,
      RG_BLINK = 3'd2,
      RG_POL   = 3'd3,
      RG_DIN   = 3'd4,
      RG_CAUSE = 3'd5,
      RG_EMASK = 3'd6,
      RG_LMASK = 3'd7
   } reg_sel_e;

   localparam int unsigned MAP_WORDS = 8;

   // Write-side request after decode
   typedef struct packed {
      logic     hit;
      reg_sel_e sel;
   } reg_req_t;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pins_raw,
   output logic [WIDTH-1:0] pins_sync
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("gpio_in_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= pins_raw;
         for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign pins_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
   import gpio_irq_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  reg_req_t         req,
   input  logic             wen,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] out_q,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] blink_q,
   output logic [WIDTH-1:0] pol_q,
   output logic [WIDTH-1:0] emask_q,
   output logic [WIDTH-1:0] lmask_q
);

   logic do_wr;
   assign do_wr = wen & req.hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q   <= '0;
         dir_q   <= '0;
         blink_q <= '0;
         pol_q   <= '0;
         emask_q <= '0;
         lmask_q <= '0;
      end else if (do_wr) begin
         unique case (req.sel)
            RG_OUT:   out_q   <= wdata;
            RG_DIR:   dir_q   <= wdata;
            RG_BLINK: blink_q <= wdata;
            RG_POL:   pol_q   <= wdata;
            RG_EMASK: emask_q <= wdata;
            RG_LMASK: lmask_q <= wdata;
            default:  ;
         endcase
      end
   end

endmodule

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   input  logic             ack_en,
   input  logic [WIDTH-1:0] ack_keep,
   output logic [WIDTH-1:0] prev_q,
   output logic [WIDTH-1:0] cause_q
);

   logic [WIDTH-1:0] rise;
   logic [WIDTH-1:0] keep;

   assign rise = din & ~prev_q;
   assign keep = ack_en ? ack_keep : '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         cause_q <= '0;
      end else begin
         prev_q  <= din;
         cause_q <= (cause_q & keep) | rise;
      end
   end

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
   parameter int unsigned WIDTH   = 32,
   parameter int unsigned GROUP_W = 8,
   localparam int unsigned NGRP   = WIDTH / GROUP_W
) (
   input  logic [WIDTH-1:0] din,
   input  logic [WIDTH-1:0] lmask,
   input  logic [WIDTH-1:0] cause,
   input  logic [WIDTH-1:0] emask,
   output logic [NGRP-1:0]  grp_irq
);

   logic [WIDTH-1:0] line_irq;
   assign line_irq = (din & lmask) | (cause & emask);

   generate
      for (genvar g = 0; g < int'(NGRP); g++) begin : g_grp
         assign grp_irq[g] = |line_irq[g*GROUP_W +: GROUP_W];
      end
   endgenerate

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NUM_LINES   = 32,
   parameter int unsigned GROUP_W     = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 6,
   localparam int unsigned NGRP       = NUM_LINES / GROUP_W,
   localparam int unsigned IDX_W      = ADDR_W - 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic                 reg_wen,
   input  logic [NUM_LINES-1:0] reg_wdata,
   output logic [NUM_LINES-1:0] reg_rdata,
   input  logic [NUM_LINES-1:0] pin_in,
   output logic [NUM_LINES-1:0] pin_out,
   output logic [NUM_LINES-1:0] pin_oe,
   output logic [NGRP-1:0]      irq_grp
);

   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("gpio_irq_port: ADDR_W must cover eight words");
      end
      if (GROUP_W == 0 || (NUM_LINES % GROUP_W) != 0) begin : g_bad_group
         $error("gpio_irq_port: NUM_LINES must be a multiple of GROUP_W");
      end
      if (NUM_LINES > 32 || NUM_LINES == 0) begin : g_bad_lines
         $error("gpio_irq_port: NUM_LINES must be 1..32");
      end
   endgenerate

   // ---------------- decode ----------------
   logic [IDX_W-1:0] word_idx;
   logic             in_map;
   reg_req_t         req;
   logic [1:0]       unused_addr_lo;

   assign word_idx       = reg_addr[ADDR_W-1:2];
   assign unused_addr_lo = reg_addr[1:0];

   generate
      if (IDX_W > 3) begin : g_wide_map
         assign in_map = ~|word_idx[IDX_W-1:3];
      end else begin : g_exact_map
         assign in_map = 1'b1;
      end
   endgenerate

   assign req.hit = in_map;
   assign req.sel = reg_sel_e'(word_idx[2:0]);

   // ---------------- state ----------------
   logic [NUM_LINES-1:0] out_w, dir_w, blink_w, pol_w, emask_w, lmask_w;
   logic [NUM_LINES-1:0] sync_w, din_w, prev_w, cause_w;
   logic                 ack_en;

   gpio_cfg_regs #(.WIDTH(NUM_LINES)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .wen     (reg_wen),
      .wdata   (reg_wdata),
      .out_q   (out_w),
      .dir_q   (dir_w),
      .blink_q (blink_w),
      .pol_q   (pol_w),
      .emask_q (emask_w),
      .lmask_q (lmask_w)
   );

   gpio_in_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .pins_raw  (pin_in),
      .pins_sync (sync_w)
   );

   assign din_w  = sync_w ^ pol_w;
   assign ack_en = reg_wen & in_map & (req.sel == RG_CAUSE);

   gpio_edge_cause #(.WIDTH(NUM_LINES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (din_w),
      .ack_en   (ack_en),
      .ack_keep (reg_wdata),
      .prev_q   (prev_w),
      .cause_q  (cause_w)
   );

   gpio_irq_merge #(.WIDTH(NUM_LINES), .GROUP_W(GROUP_W)) u_merge (
      .din     (din_w),
      .lmask   (lmask_w),
      .cause   (cause_w),
      .emask   (emask_w),
      .grp_irq (irq_grp)
   );

   // ---------------- outputs ----------------
   assign pin_out = out_w;
   assign pin_oe  = ~dir_w;

   always_comb begin
      reg_rdata = '0;
      if (in_map) begin
         unique case (req.sel)
            RG_OUT:   reg_rdata = out_w;
            RG_DIR:   reg_rdata = dir_w;
            RG_BLINK: reg_rdata = blink_w;
            RG_POL:   reg_rdata = pol_w;
            RG_DIN:   reg_rdata = din_w;
            RG_CAUSE: reg_rdata = cause_w;
            RG_EMASK: reg_rdata = emask_w;
            RG_LMASK: reg_rdata = lmask_w;
            default:  reg_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
   parameter int unsigned NUM_LINES = 32,
   parameter int unsigned NGRP      = 4,
   parameter int unsigned ADDR_W    = 6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    reg_addr,
   input logic                 reg_wen,
   input logic [NUM_LINES-1:0] reg_wdata,
   input logic [NUM_LINES-1:0] reg_rdata,
   input logic [NUM_LINES-1:0] pin_oe,
   input logic [NGRP-1:0]      irq_grp,
   input logic [NUM_LINES-1:0] din,
   input logic [NUM_LINES-1:0] prev,
   input logic [NUM_LINES-1:0] cause,
   input logic [NUM_LINES-1:0] emask,
   input logic [NUM_LINES-1:0] lmask
);

   logic is_dir_wr, is_cause_wr, unmapped;
   logic [NUM_LINES-1:0] rise_seen;

   assign is_dir_wr   = reg_wen && ({1'b0, reg_addr} >> 2) == (ADDR_W+1)'(1);
   assign is_cause_wr = reg_wen && ({1'b0, reg_addr} >> 2) == (ADDR_W+1)'(5);
   assign unmapped    = {1'b0, reg_addr} >= (ADDR_W+1)'(32);
   assign rise_seen   = din & ~prev;

   AST_RESET_ZERO: assert property (@(posedge clk)
      !rst_n |=> (cause == '0 && emask == '0 && lmask == '0 && irq_grp == '0)); // R1

   AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      is_dir_wr |=> pin_oe == ~$past(reg_wdata)); // R2

   AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_seen != '0) |=> ((cause & $past(rise_seen)) == $past(rise_seen))); // R5

   AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !is_cause_wr |=> ((cause & $past(cause)) == $past(cause))); // R6

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (emask == '0 && lmask == '0) |-> irq_grp == '0); // R7

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped |-> reg_rdata == '0); // R8

endmodule

bind gpio_irq_port gpio_irq_port_chk #(
   .NUM_LINES (NUM_LINES),
   .NGRP      (NGRP),
   .ADDR_W    (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wen   (reg_wen),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .pin_oe    (pin_oe),
   .irq_grp   (irq_grp),
   .din       (din_w),
   .prev      (prev_w),
   .cause     (cause_w),
   .emask     (emask_w),
   .lmask     (lmask_w)
);

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;

   localparam int W = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [5:0]    reg_addr;
   logic          reg_wen;
   logic [W-1:0]  reg_wdata;
   logic [W-1:0]  reg_rdata;
   logic [W-1:0]  pin_in;
   logic [W-1:0]  pin_out;
   logic [W-1:0]  pin_oe;
   logic [3:0]    irq_grp;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   gpio_irq_port u_gpio_irq_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wen   (reg_wen),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .irq_grp   (irq_grp)
   );

   // ---------------- behavioural reference ----------------
   bit [W-1:0] m_out, m_dir, m_blink, m_pol, m_em, m_lm;
   bit [W-1:0] m_sa, m_sb, m_last, m_cause;
   bit [W-1:0] cur_pins;

   function automatic bit [W-1:0] m_corr();
      bit [W-1:0] v;
      for (int i = 0; i < W; i++) v[i] = m_sb[i] ^ m_pol[i];
      return v;
   endfunction

   task automatic model_clear();
      m_out = 0; m_dir = 0; m_blink = 0; m_pol = 0; m_em = 0; m_lm = 0;
      m_sa = 0; m_sb = 0; m_last = 0; m_cause = 0;
   endtask

   task automatic model_step();
      bit [W-1:0] now, keep;
      int widx;
      now  = m_corr();
      keep = '1;
      widx = int'(reg_addr) / 4;
      if (reg_wen && reg_addr < 6'd32) begin
         case (widx)
            0: m_out   = reg_wdata;
            1: m_dir   = reg_wdata;
            2: m_blink = reg_wdata;
            3: m_pol   = reg_wdata;
            5: keep    = reg_wdata;
            6: m_em    = reg_wdata;
            7: m_lm    = reg_wdata;
            default: ;
         endcase
      end
      for (int i = 0; i < W; i++) begin
         bit up;
         up = now[i] && !m_last[i];
         m_cause[i] = (m_cause[i] && keep[i]) || up;
      end
      m_last = now;
      m_sb   = m_sa;
      m_sa   = pin_in;
   endtask

   function automatic bit [W-1:0] exp_rd();
      if (reg_addr >= 6'd32) return '0;
      case (int'(reg_addr) / 4)
         0: return m_out;
         1: return m_dir;
         2: return m_blink;
         3: return m_pol;
         4: return m_corr();
         5: return m_cause;
         6: return m_em;
         default: return m_lm;
      endcase
   endfunction

   function automatic bit [3:0] exp_irq();
      bit [3:0] r;
      bit [W-1:0] d;
      d = m_corr();
      r = '0;
      for (int g = 0; g < 4; g++)
         for (int k = 0; k < 8; k++) begin
            int i;
            i = g * 8 + k;
            if ((d[i] && m_lm[i]) || (m_cause[i] && m_em[i])) r[g] = 1'b1;
         end
      return r;
   endfunction

   function automatic string rd_req();
      if (reg_addr >= 6'd32) return "R8";
      case (int'(reg_addr) / 4)
         4: return "R4";
         5: return "R6";
         default: return "R3";
      endcase
   endfunction

   // ---------------- checking ----------------
   task automatic chk(input string req, input string what,
                      input logic [W-1:0] got, input logic [W-1:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h at %0t", req, what, got, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk(rd_req(), "reg_rdata", reg_rdata, exp_rd());
      chk("R2", "pin_out", pin_out, m_out);
      chk("R2", "pin_oe", pin_oe, ~m_dir);
      chk("R7", "irq_grp", {28'd0, irq_grp}, {28'd0, exp_irq()});
   endtask

   // one clock: drive at negedge, advance model, compare at next negedge
   task automatic step(input logic [5:0] a, input logic w, input logic [W-1:0] d);
      reg_addr  = a;
      reg_wen   = w;
      reg_wdata = d;
      pin_in    = cur_pins;
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   task automatic wr(input logic [5:0] a, input logic [W-1:0] d);
      step(a, 1'b1, d);
   endtask

   task automatic rd(input logic [5:0] a);
      step(a, 1'b0, '0);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, got hang expected completion");
         summary();
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      rst_n     = 1'b0;
      reg_addr  = '0;
      reg_wen   = 1'b0;
      reg_wdata = '0;
      cur_pins  = '0;
      pin_in    = '0;
      model_clear();
      repeat (3) @(negedge clk);

      // R1: reset values while reset is held
      chk("R1", "pin_oe in reset", pin_oe, '1);
      chk("R1", "pin_out in reset", pin_out, '0);
      chk("R1", "irq in reset", {28'd0, irq_grp}, '0);
      rst_n = 1'b1;
      for (int a = 0; a < 64; a += 4) begin
         rd(6'(a));
         chk("R1", "read after reset", reg_rdata, '0);
      end

      // R3: readback of storage words, blink included
      wr(6'h00, 32'hA5A5_0F0F);
      wr(6'h04, 32'h0000_FFFF);
      wr(6'h08, 32'h1357_9BDF);
      rd(6'h00); chk("R3", "output word", reg_rdata, 32'hA5A5_0F0F);
      rd(6'h08); chk("R3", "blink word", reg_rdata, 32'h1357_9BDF);
      // R2: direction word drives enables
      chk("R2", "pin_oe after dir", pin_oe, 32'hFFFF_0000);
      chk("R2", "pin_out after out", pin_out, 32'hA5A5_0F0F);

      // R8: writes to data-in and unmapped offsets change nothing
      wr(6'h10, 32'hFFFF_FFFF);
      rd(6'h10); chk("R8", "data-in after write", reg_rdata, '0);
      wr(6'h24, 32'hDEAD_BEEF);
      wr(6'h3C, 32'hFFFF_FFFF);
      rd(6'h24); chk("R8", "unmapped read", reg_rdata, '0);
      rd(6'h00); chk("R8", "output word kept", reg_rdata, 32'hA5A5_0F0F);

      // R4/R5: rising pin on line 9, two-edge latency then cause
      wr(6'h18, 32'h0000_0200);
      cur_pins = 32'h0000_0200;
      rd(6'h14);
      rd(6'h14); chk("R5", "no cause before corrected input moves", reg_rdata, '0);
      rd(6'h14); chk("R5", "cause bit 9 set", reg_rdata, 32'h0000_0200);
      chk("R7", "group 1 raised", {28'd0, irq_grp}, 32'h2);
      rd(6'h10); chk("R4", "data-in line 9", reg_rdata, 32'h0000_0200);

      // R6: write all ones except bit 9 acknowledges only that bit
      cur_pins = 32'h0000_0000;
      wr(6'h14, 32'hFFFF_FDFF);
      rd(6'h14); chk("R6", "cause cleared", reg_rdata, '0);

      // R6: edge in the same cycle as a full clear
      cur_pins = 32'h0010_0000;
      rd(6'h14);
      rd(6'h14);
      wr(6'h14, 32'h0000_0000);
      rd(6'h14); chk("R6", "set beats clear", reg_rdata, 32'h0010_0000);
      wr(6'h14, 32'h0000_0000);
      rd(6'h14); chk("R6", "later clear works", reg_rdata, '0);

      // R5: falling edge via inversion on line 26
      cur_pins = 32'h0410_0000;
      repeat (3) rd(6'h14);
      wr(6'h14, 32'h0000_0000);
      wr(6'h0C, 32'h0400_0000);
      wr(6'h14, 32'h0000_0000);
      rd(6'h14); chk("R5", "no cause while pin high inverted", reg_rdata, '0);
      cur_pins = 32'h0010_0000;
      repeat (3) rd(6'h14);
      chk("R5", "falling edge latched", reg_rdata, 32'h0400_0000);
      wr(6'h14, 32'h0000_0000);
      wr(6'h18, 32'h0000_0000);

      // R9: active-low level on line 3
      wr(6'h0C, 32'h0000_0008);
      wr(6'h1C, 32'h0000_0008);
      rd(6'h10); chk("R9", "pin low raises group 0", {28'd0, irq_grp}, 32'h1);
      cur_pins = 32'h0010_0008;
      rd(6'h10);
      rd(6'h10); chk("R9", "pin high drops group 0", {28'd0, irq_grp}, '0);
      wr(6'h1C, 32'h0000_0000);

      // R7: each group on its own through the level mask
      cur_pins = 32'hFFFF_FFFF;
      wr(6'h0C, 32'h0000_0000);
      rd(6'h10); rd(6'h10);
      for (int g = 0; g < 4; g++) begin
         wr(6'h1C, 32'h1 << (g * 8 + 7));
         rd(6'h1C);
         chk("R7", "single group", {28'd0, irq_grp}, 32'h1 << g);
      end

      // random mix
      for (int n = 0; n < 3000; n++) begin
         if ($urandom_range(0, 3) == 0) cur_pins = cur_pins ^ (32'h1 << $urandom_range(0, 31));
         if ($urandom_range(0, 2) == 0)
            step(6'($urandom_range(0, 63)), 1'b1, 32'($urandom) | 32'($urandom));
         else
            step(6'($urandom_range(0, 63)), 1'b0, '0);
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule